// File: doc/BRIEF.md
# Two-Bit Direction Sequence Generator

This block produces a repeatable stream of four-way direction codes for a memory game. An 8-bit linear feedback shift register holds the state. The two least significant stages are read as the current direction: 0 is up, 1 is right, 2 is left and 3 is down. The surrounding game logic loads a seed from eight slide switches before each round. It then pulses a step strobe each time it has used a direction. Each step advances the register by two single-bit shifts within one clock cycle, so the next direction appears at once. Loading the same seed again replays the same stream.

Feedback follows the degree-8 connection polynomial with taps at degrees 4, 5, 6 and 8. In a register that shifts toward bit 0, one shift moves every stage down one place. The vacated top stage takes s4 ^ s3 ^ s2 ^ s0. The sequence is maximal, so every nonzero state recurs after 255 single shifts. Because 255 is odd, the double-shift step also cycles through all 255 nonzero states. The all-zero state would lock the register, so a zero seed is never loaded. The block substitutes a fixed nonzero fill instead and raises a flag that stays up until a valid seed is loaded.

A small controller tracks where the current state came from. Its states are:
- BOOT: the default fill, placed there by reset.
- USER: a valid user seed.
- SUBST: the default fill, substituted for a rejected zero seed.

The controller has three transitions:
- Reset moves it to BOOT.
- A load with a nonzero seed moves it from any state to USER.
- A load with a zero seed moves it from any state to SUBST.

Steps and idle cycles keep the controller in its current state. In every cycle the controller also picks the source of the next register value: hold, seed, fill or advance.

Top module: `dirgen_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the state equals the default fill 8'h5B. `dir_o` reads 2'b11 and `seed_bad_o` is low.
- R2: A `load_i` cycle with a nonzero `seed_i` places the seed in the register. From the next cycle `dir_o` equals `seed_i[1:0]` and `seed_bad_o` is low.
- R3: A `step_i` cycle without a load applies the single shift twice. The single shift is new[7] = s4^s3^s2^s0 and new[6:0] = s[7:1]. The result is visible on `dir_o` in the next cycle.
- R4: `dir_o` is the low two bits of the state: 2'b00 up, 2'b01 right, 2'b10 left, 2'b11 down.
- R5: A `load_i` cycle with `seed_i` equal to zero places the default fill 8'h5B in the register and raises `seed_bad_o` from the next cycle.
- R6: When `load_i` and `step_i` are high together, the load takes effect and the step is ignored.
- R7: A cycle with neither `load_i` nor `step_i` leaves `dir_o` and `seed_bad_o` unchanged.
- R8: Loading the same seed again reproduces the same direction stream step for step.
- R9: The state never becomes zero. From any nonzero seed, the stream of directions repeats after exactly 255 steps.
- R10: `seed_bad_o` stays high across steps and idle cycles until a nonzero seed is loaded or reset is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Load strobe for the seed |
| seed_i | input | 8 | Seed value from the switches |
| step_i | input | 1 | Advance strobe, two shifts per pulse |
| dir_o | output | 2 | Current direction code |
| seed_bad_o | output | 1 | Last loaded seed was zero and was replaced |

## Verification
A wrong tap, a missing second shift or a swapped shift direction changes the register contents. The fault can take a few steps to reach the two observed stages, because the bits it corrupts must shift down to bit 1 or bit 0 first. A full mismatch therefore shows on `dir_o` within about four steps of the seed load. Comparing every step against an arithmetic model over all 256 seeds exposes it. A fault in the source selection, such as a wrong priority, a lost fill or a lost hold, shows on `dir_o` or `seed_bad_o` one cycle after the offending strobe. A period fault only appears after the full 255-step loop. The bench runs that loop and compares it against the recorded start of the stream.

// File: rtl/dirgen_pkg.sv
`timescale 1ns/1ps
package dirgen_pkg;

    typedef enum logic [1:0] {
        DIR_UP    = 2'd0,
        DIR_RIGHT = 2'd1,
        DIR_LEFT  = 2'd2,
        DIR_DOWN  = 2'd3
    } dir_e;

    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_USER  = 2'd1,
        ST_SUBST = 2'd2
    } seed_st_e;

    typedef enum logic [1:0] {
        SEL_HOLD = 2'd0,
        SEL_SEED = 2'd1,
        SEL_FILL = 2'd2,
        SEL_ADV  = 2'd3
    } src_sel_e;

endpackage

// File: rtl/dirgen_shift.sv
`timescale 1ns/1ps
module dirgen_shift #(
    parameter int          WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'h1D
) (
    input  logic [WIDTH-1:0] s_i,
    output logic [WIDTH-1:0] s_o
);
    // One shift toward bit 0; the vacated top stage takes the tapped parity.
    logic fb_w;
    assign fb_w = ^(s_i & TAP_MASK);
    assign s_o  = {fb_w, s_i[WIDTH-1:1]};
endmodule

// File: rtl/dirgen_advance.sv
`timescale 1ns/1ps
module dirgen_advance #(
    parameter int               WIDTH    = 8,
    parameter logic [WIDTH-1:0] TAP_MASK = 8'h1D,
    parameter int               SHIFTS   = 2
) (
    input  logic [WIDTH-1:0] s_i,
    output logic [WIDTH-1:0] s_o
);
    logic [WIDTH-1:0] chain_w [SHIFTS+1];

    assign chain_w[0] = s_i;

    for (genvar g = 0; g < SHIFTS; g++) begin : g_stage
        dirgen_shift #(
            .WIDTH    (WIDTH),
            .TAP_MASK (TAP_MASK)
        ) shift_i (
            .s_i (chain_w[g]),
            .s_o (chain_w[g+1])
        );
    end

    assign s_o = chain_w[SHIFTS];
endmodule

// File: rtl/dirgen_ctrl.sv
`timescale 1ns/1ps
module dirgen_ctrl
    import dirgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load_i,
    input  logic     step_i,
    input  logic     seed_zero_i,
    output src_sel_e sel_o,
    output logic     flag_o
);
    seed_st_e st_q, st_d;

    // Next-state logic: only a load moves the origin tracker.
    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d = seed_zero_i ? ST_SUBST : ST_USER;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_BOOT;
        end else begin
            st_q <= st_d;
        end
    end

    // Outputs: register source select (load over step) and the flag.
    always_comb begin
        if (load_i) begin
            sel_o = seed_zero_i ? SEL_FILL : SEL_SEED;
        end else if (step_i) begin
            sel_o = SEL_ADV;
        end else begin
            sel_o = SEL_HOLD;
        end

        unique case (st_q)
            ST_BOOT:  flag_o = 1'b0;
            ST_USER:  flag_o = 1'b0;
            ST_SUBST: flag_o = 1'b1;
            default:  flag_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dirgen_top.sv
`timescale 1ns/1ps
module dirgen_top
    import dirgen_pkg::*;
#(
    parameter int         WIDTH        = 8,
    parameter logic [7:0] TAP_MASK     = 8'h1D,
    parameter int         SHIFTS       = 2,
    parameter logic [7:0] DEFAULT_FILL = 8'h5B
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] seed_i,
    input  logic       step_i,
    output logic [1:0] dir_o,
    output logic       seed_bad_o
);
    localparam logic [WIDTH-1:0] FILL_W = DEFAULT_FILL[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TAPS_W = TAP_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] state_q, state_d, adv_w;
    logic             seed_zero_w;
    src_sel_e         sel_w;
    logic             flag_w;

    assign seed_zero_w = (seed_i[WIDTH-1:0] == '0);

    dirgen_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .load_i      (load_i),
        .step_i      (step_i),
        .seed_zero_i (seed_zero_w),
        .sel_o       (sel_w),
        .flag_o      (flag_w)
    );

    dirgen_advance #(
        .WIDTH    (WIDTH),
        .TAP_MASK (TAPS_W),
        .SHIFTS   (SHIFTS)
    ) adv_i (
        .s_i (state_q),
        .s_o (adv_w)
    );

    always_comb begin
        unique case (sel_w)
            SEL_SEED: state_d = seed_i[WIDTH-1:0];
            SEL_FILL: state_d = FILL_W;
            SEL_ADV:  state_d = adv_w;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FILL_W;
        end else begin
            state_q <= state_d;
        end
    end

    assign dir_o      = state_q[1:0];
    assign seed_bad_o = flag_w;
endmodule

// File: rtl/dirgen_chk.sv
`timescale 1ns/1ps
module dirgen_chk #(
    parameter int         WIDTH        = 8,
    parameter logic [7:0] DEFAULT_FILL = 8'h5B
) (
    input logic             clk,
    input logic             rst,
    input logic             load_i,
    input logic [7:0]       seed_i,
    input logic             step_i,
    input logic [1:0]       dir_o,
    input logic             seed_bad_o,
    input logic [WIDTH-1:0] state_q
);
    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i != 8'h00) |=> (!seed_bad_o && dir_o == $past(seed_i[1:0])));

    // R5
    zero_subst_chk: assert property (@(posedge clk) disable iff (rst)
        (load_i && seed_i == 8'h00) |=> (seed_bad_o && dir_o == DEFAULT_FILL[1:0]));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !step_i) |=> ($stable(dir_o) && $stable(seed_bad_o)));

    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_i && step_i) |=> $stable(seed_bad_o));

    // R9
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);
endmodule

bind dirgen_top dirgen_chk #(
    .WIDTH        (WIDTH),
    .DEFAULT_FILL (DEFAULT_FILL)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load_i),
    .seed_i     (seed_i),
    .step_i     (step_i),
    .dir_o      (dir_o),
    .seed_bad_o (seed_bad_o),
    .state_q    (state_q)
);

// File: tb/dirgen_top_tb_top.sv
`timescale 1ns/1ps
module dirgen_top_tb_top;
    localparam logic [7:0] FILL = 8'h5B;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_i;
    logic [7:0] seed_i;
    logic       step_i;
    logic [1:0] dir_o;
    logic       seed_bad_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] exp_st;
    logic       exp_flag;
    logic [1:0] rec [16];

    always #5 clk = ~clk;

    dirgen_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (load_i),
        .seed_i     (seed_i),
        .step_i     (step_i),
        .dir_o      (dir_o),
        .seed_bad_o (seed_bad_o)
    );

    function automatic logic [7:0] one_shift(input logic [7:0] s);
        return {s[4] ^ s[3] ^ s[2] ^ s[0], s[7:1]};
    endfunction

    function automatic logic [7:0] two_shift(input logic [7:0] s);
        return one_shift(one_shift(s));
    endfunction

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    // Drive at the falling edge, let one rising edge pass, release strobes.
    task automatic cyc(input logic ld, input logic [7:0] sd, input logic st);
        load_i = ld;
        seed_i = sd;
        step_i = st;
        @(negedge clk);
        load_i = 1'b0;
        step_i = 1'b0;
    endtask

    task automatic chk_out(input string tag);
        chk(tag, {6'd0, dir_o}, {6'd0, exp_st[1:0]});
        chk({tag, " flag"}, {7'd0, seed_bad_o}, {7'd0, exp_flag});
    endtask

    initial begin
        rst = 1'b1; load_i = 1'b0; step_i = 1'b0; seed_i = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_st = FILL; exp_flag = 1'b0;
        chk_out("R1 reset");
        cyc(0, 8'h00, 1); exp_st = two_shift(exp_st);
        chk_out("R3 step from reset");

        // Sweep every seed: load, several steps, one idle cycle.
        for (int s = 0; s < 256; s++) begin
            cyc(1, s[7:0], 0);
            if (s == 0) begin
                exp_st = FILL; exp_flag = 1'b1;
                chk_out("R5 zero seed");
            end else begin
                exp_st = s[7:0]; exp_flag = 1'b0;
                chk_out("R2 R4 load");
            end
            for (int k = 0; k < 6; k++) begin
                cyc(0, 8'h00, 1); exp_st = two_shift(exp_st);
                chk_out(s == 0 ? "R10 step flag" : "R3 R4 step");
            end
            cyc(0, 8'hFF, 0);
            chk_out("R7 idle hold");
        end

        // R6: load and step together.
        cyc(1, 8'h3C, 1); exp_st = 8'h3C; exp_flag = 1'b0;
        chk_out("R6 load priority");
        cyc(1, 8'h00, 1); exp_st = FILL; exp_flag = 1'b1;
        chk_out("R6 zero load priority");
        cyc(0, 8'h00, 0);
        chk_out("R10 flag held idle");
        cyc(1, 8'h81, 0); exp_st = 8'h81; exp_flag = 1'b0;
        chk_out("R10 flag cleared");

        // R8: replay after reseed.
        cyc(1, 8'h6E, 0);
        for (int k = 0; k < 16; k++) begin
            rec[k] = dir_o;
            cyc(0, 8'h00, 1);
        end
        cyc(1, 8'hC3, 0);
        repeat (5) cyc(0, 8'h00, 1);
        cyc(1, 8'h6E, 0);
        for (int k = 0; k < 16; k++) begin
            chk("R8 replay", {6'd0, dir_o}, {6'd0, rec[k]});
            cyc(0, 8'h00, 1);
        end

        // R9: full loop of 255 steps from seed 1.
        cyc(1, 8'h01, 0); exp_st = 8'h01; exp_flag = 1'b0;
        for (int k = 0; k < 255; k++) begin
            if (k < 16) rec[k] = dir_o;
            chk_out("R9 loop");
            cyc(0, 8'h00, 1); exp_st = two_shift(exp_st);
        end
        for (int k = 0; k < 16; k++) begin
            chk("R9 period", {6'd0, dir_o}, {6'd0, rec[k]});
            cyc(0, 8'h00, 1);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule